// File: doc/BRIEF.md
# Serial Command Receiver and Decoder for a Dot-Matrix Display Controller

This block takes the three-wire serial link from a host (an active-low chip select, a shift clock and a data line) and turns it into write strobes toward three display memories plus updates to a small set of control registers. The serial pins are brought into the system clock domain through synchronizers and sampled there. Bits are shifted in least-significant first on each rising shift clock while chip select is low, and every eighth bit produces an internal byte strobe.

The first complete byte of each transfer is a command. Its top three bits pick an operation. A control command updates one register at once, and the byte after it is again read as a command. A memory command loads a start address and switches the transfer into data mode. Each later byte in the same transfer is then written to one of three memories, and the address advances by itself.

The three memories are a character-code memory (8-bit entries), a symbol memory (4-bit entries), and a pattern memory that is written one 7-bit column at a time in groups of five. The character-code and symbol memories each have 24 live slots. Their 5-bit address also runs through 8 dummy slots, where bytes are swallowed without a write. A transfer ends when chip select rises; any partial byte is then dropped and the next transfer starts in command mode.

Top module: `vfd_serial_cmd`

## Requirements
- R1: A bit is taken only on a rising edge of `ser_sck` while `ser_csn` is low, and the first bit taken is the least significant bit of the byte. Shift-clock edges seen while `ser_csn` is high have no effect.
- R2: The first complete byte after `ser_csn` falls is a command. Its opcode is the byte's bits [7:5] read as an unsigned number: 1 = character-code write, 2 = pattern write, 3 = symbol write, 4 = port set, 5 = duty set, 6 = digit-count set, 7 = all-lights set.
- R3: Port set loads `port_q` from bits [3:0], duty set loads `duty_q` from bits [2:0], and digit-count set loads `digits_q` from bits [3:0]. All-lights set loads `lamp_q` from bits [1:0]: bit 0 forces all outputs off and bit 1 forces them on. After any of these commands the transfer stays in command mode, so the next byte is decoded as a command.
- R4: Character-code write takes its start address from bits [4:0]. Each following byte is written whole at the current address, and the address then rises by one.
- R5: In character-code and symbol modes, addresses 24 to 31 are dummy slots. A byte sent to a dummy slot produces no write strobe, but it still advances the address. The address wraps from 31 to 0.
- R6: Pattern write takes its start address from bits [3:0]. Following bytes are written with data bits [6:0] and a column index that counts 0 to 4; bit 7 is ignored. After column 4 the column returns to 0 and the address rises by one, wrapping from 15 to 0.
- R7: Symbol write takes its start address from bits [4:0]. Each following byte is written using only bits [3:0], and the address then rises by one.
- R8: While `rst` is high (synchronous, active high), all write strobes are low and all addresses are 0. `port_q`, `duty_q` and `digits_q` are 0, and `lamp_q` is 2'b01 (forced off).
- R9: Data mode lasts until `ser_csn` rises. The first byte of the next transfer is decoded as a command.
- R10: Bits left over when `ser_csn` rises, short of a full byte, are discarded, and the next transfer counts bits from zero.
- R11: A command with opcode 0 changes no register and causes no write.
- R12: If a byte completes in the same clock cycle that the rise of `ser_csn` is seen, that byte is still acted on, and the transfer then ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_csn | input | 1 | Serial chip select, active low |
| ser_sck | input | 1 | Serial shift clock; data taken on its rising edge |
| ser_dat | input | 1 | Serial data, LSB first |
| code_we | output | 1 | Character-code memory write strobe |
| code_addr | output | 5 | Character-code memory write address |
| code_wdata | output | 8 | Character-code memory write data |
| pat_we | output | 1 | Pattern memory write strobe |
| pat_addr | output | 4 | Pattern memory entry address |
| pat_col | output | 3 | Pattern column index 0..4 |
| pat_wdata | output | 7 | Pattern column data |
| sym_we | output | 1 | Symbol memory write strobe |
| sym_addr | output | 5 | Symbol memory write address |
| sym_wdata | output | 4 | Symbol memory write data |
| port_q | output | 4 | General output port register |
| duty_q | output | 3 | Brightness duty register |
| digits_q | output | 4 | Digit-count register |
| lamp_q | output | 2 | All-lights override: bit 0 forces off, bit 1 forces on |

## Verification
Two events can fall in one cycle: the byte-complete strobe, which carries a memory write, and the end of the transfer at the rise of chip select. The bench provokes this by raising the shift clock for the eighth data bit at the same instant that chip select rises. Both edges pass through identical synchronizers, so they arrive together. The case is judged correct if the character-code write for that byte still appears with the right address and data, and if the first byte of the following transfer updates a register instead of being written to memory.

// File: rtl/vfd_cmd_pkg.sv
package vfd_cmd_pkg;

    // Command byte layout: opcode in the top three bits
    localparam int BYTE_W  = 8;
    localparam int OP_LSB  = 5;
    localparam int OP_W    = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NONE = 3'd0,
        OP_CODE = 3'd1,
        OP_PAT  = 3'd2,
        OP_SYM  = 3'd3,
        OP_PORT = 3'd4,
        OP_DUTY = 3'd5,
        OP_DIGS = 3'd6,
        OP_LAMP = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        M_CMD,
        M_CODE,
        M_PAT,
        M_SYM
    } mode_e;

    typedef struct packed {
        logic port;
        logic duty;
        logic digs;
        logic lamp;
    } ctl_sel_t;

    // All-lights value after reset: forced off
    localparam logic [1:0] LAMP_RST = 2'b01;

    function automatic op_e op_of(input logic [BYTE_W-1:0] b);
        return op_e'(b[OP_LSB +: OP_W]);
    endfunction

endpackage

// File: rtl/vfd_ser_front.sv
module vfd_ser_front
    import vfd_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csn_i,
    input  logic              sck_i,
    input  logic              dat_i,
    output logic              byte_vld_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              xfer_end_o
);

    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    logic csn_s, sck_s, dat_s;
    logic csn_d, sck_d;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              take;
    logic [BYTE_W-1:0] shreg_nxt;

    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (rst) begin
                    csn_s <= 1'b1;
                    sck_s <= 1'b0;
                    dat_s <= 1'b0;
                end else begin
                    csn_s <= csn_i;
                    sck_s <= sck_i;
                    dat_s <= dat_i;
                end
            end
        end else begin : g_syncn
            logic [SYNC_STAGES-1:0] csn_sh, sck_sh, dat_sh;
            always_ff @(posedge clk) begin
                if (rst) begin
                    csn_sh <= '1;
                    sck_sh <= '0;
                    dat_sh <= '0;
                end else begin
                    csn_sh <= {csn_sh[SYNC_STAGES-2:0], csn_i};
                    sck_sh <= {sck_sh[SYNC_STAGES-2:0], sck_i};
                    dat_sh <= {dat_sh[SYNC_STAGES-2:0], dat_i};
                end
            end
            assign csn_s = csn_sh[SYNC_STAGES-1];
            assign sck_s = sck_sh[SYNC_STAGES-1];
            assign dat_s = dat_sh[SYNC_STAGES-1];
        end
    endgenerate

    // A bit is taken on a shift-clock rise while select was low last cycle
    assign take      = sck_s & ~sck_d & ~csn_d;
    assign shreg_nxt = {dat_s, shreg[BYTE_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            csn_d      <= 1'b1;
            sck_d      <= 1'b0;
            bit_cnt    <= '0;
            shreg      <= '0;
            byte_vld_o <= 1'b0;
            byte_o     <= '0;
            xfer_end_o <= 1'b0;
        end else begin
            csn_d      <= csn_s;
            sck_d      <= sck_s;
            byte_vld_o <= 1'b0;
            xfer_end_o <= csn_s & ~csn_d;
            if (csn_d) begin
                bit_cnt <= '0;
            end else if (take) begin
                shreg   <= shreg_nxt;
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_LAST) begin
                    byte_vld_o <= 1'b1;
                    byte_o     <= shreg_nxt;
                end
            end
        end
    end

    // R10: the bit count is cleared while select is high
    a_r10_cnt_cleared: assert property (@(posedge clk) disable iff (rst)
        csn_d |=> (bit_cnt == '0));

    // R1: two bytes can never complete in back-to-back cycles
    a_r1_byte_spacing: assert property (@(posedge clk) disable iff (rst)
        byte_vld_o |=> !byte_vld_o);

endmodule

// File: rtl/vfd_cmd_decode.sv
module vfd_cmd_decode
    import vfd_cmd_pkg::*;
#(
    parameter int CODE_AW    = 5,
    parameter int CODE_DEPTH = 24,
    parameter int CODE_DW    = 8,
    parameter int PAT_AW     = 4,
    parameter int PAT_COLS   = 5,
    parameter int PAT_DW     = 7,
    parameter int SYM_AW     = 5,
    parameter int SYM_DEPTH  = 24,
    parameter int SYM_DW     = 4,
    parameter int ARG_W      = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         byte_vld_i,
    input  logic [BYTE_W-1:0]            byte_i,
    input  logic                         xfer_end_i,
    output logic                         code_we_o,
    output logic [CODE_AW-1:0]           code_addr_o,
    output logic [CODE_DW-1:0]           code_data_o,
    output logic                         pat_we_o,
    output logic [PAT_AW-1:0]            pat_addr_o,
    output logic [$clog2(PAT_COLS)-1:0]  pat_col_o,
    output logic [PAT_DW-1:0]            pat_data_o,
    output logic                         sym_we_o,
    output logic [SYM_AW-1:0]            sym_addr_o,
    output logic [SYM_DW-1:0]            sym_data_o,
    output ctl_sel_t                     ctl_sel_o,
    output logic [ARG_W-1:0]             ctl_arg_o
);

    localparam int COL_W = $clog2(PAT_COLS);
    localparam logic [COL_W-1:0]  COL_LAST = COL_W'(PAT_COLS - 1);
    localparam logic [CODE_AW:0]  CODE_LIM = (CODE_AW + 1)'(CODE_DEPTH);
    localparam logic [SYM_AW:0]   SYM_LIM  = (SYM_AW + 1)'(SYM_DEPTH);

    mode_e              mode;
    logic [CODE_AW-1:0] code_ptr;
    logic [PAT_AW-1:0]  pat_ptr;
    logic [COL_W-1:0]   pat_col;
    logic [SYM_AW-1:0]  sym_ptr;
    op_e                op;
    logic               is_cmd;
    logic               code_live, sym_live;

    assign op        = op_of(byte_i);
    assign is_cmd    = byte_vld_i && (mode == M_CMD);
    assign code_live = ({1'b0, code_ptr} < CODE_LIM);
    assign sym_live  = ({1'b0, sym_ptr} < SYM_LIM);

    always_comb begin
        ctl_sel_o.port = is_cmd && (op == OP_PORT);
        ctl_sel_o.duty = is_cmd && (op == OP_DUTY);
        ctl_sel_o.digs = is_cmd && (op == OP_DIGS);
        ctl_sel_o.lamp = is_cmd && (op == OP_LAMP);
        ctl_arg_o      = byte_i[ARG_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode        <= M_CMD;
            code_ptr    <= '0;
            pat_ptr     <= '0;
            pat_col     <= '0;
            sym_ptr     <= '0;
            code_we_o   <= 1'b0;
            code_addr_o <= '0;
            code_data_o <= '0;
            pat_we_o    <= 1'b0;
            pat_addr_o  <= '0;
            pat_col_o   <= '0;
            pat_data_o  <= '0;
            sym_we_o    <= 1'b0;
            sym_addr_o  <= '0;
            sym_data_o  <= '0;
        end else begin
            code_we_o <= 1'b0;
            pat_we_o  <= 1'b0;
            sym_we_o  <= 1'b0;
            if (byte_vld_i) begin
                case (mode)
                    M_CMD: begin
                        case (op)
                            OP_CODE: begin
                                mode     <= M_CODE;
                                code_ptr <= byte_i[CODE_AW-1:0];
                            end
                            OP_PAT: begin
                                mode    <= M_PAT;
                                pat_ptr <= byte_i[PAT_AW-1:0];
                                pat_col <= '0;
                            end
                            OP_SYM: begin
                                mode    <= M_SYM;
                                sym_ptr <= byte_i[SYM_AW-1:0];
                            end
                            default: ;
                        endcase
                    end
                    M_CODE: begin
                        if (code_live) begin
                            code_we_o   <= 1'b1;
                            code_addr_o <= code_ptr;
                            code_data_o <= byte_i[CODE_DW-1:0];
                        end
                        code_ptr <= code_ptr + 1'b1;
                    end
                    M_PAT: begin
                        pat_we_o   <= 1'b1;
                        pat_addr_o <= pat_ptr;
                        pat_col_o  <= pat_col;
                        pat_data_o <= byte_i[PAT_DW-1:0];
                        if (pat_col == COL_LAST) begin
                            pat_col <= '0;
                            pat_ptr <= pat_ptr + 1'b1;
                        end else begin
                            pat_col <= pat_col + 1'b1;
                        end
                    end
                    M_SYM: begin
                        if (sym_live) begin
                            sym_we_o   <= 1'b1;
                            sym_addr_o <= sym_ptr;
                            sym_data_o <= byte_i[SYM_DW-1:0];
                        end
                        sym_ptr <= sym_ptr + 1'b1;
                    end
                    default: ;
                endcase
            end
            // R12: a byte finishing with the transfer is handled above first
            if (xfer_end_i) begin
                mode <= M_CMD;
            end
        end
    end

    // R4: after a character-code write the pointer sits one past it
    a_r4_code_step: assert property (@(posedge clk) disable iff (rst)
        code_we_o |-> (code_ptr == code_addr_o + 1'b1));

    // R5: dummy slots never reach the memories
    a_r5_code_live_only: assert property (@(posedge clk) disable iff (rst)
        code_we_o |-> ({1'b0, code_addr_o} < CODE_LIM));
    a_r5_sym_live_only: assert property (@(posedge clk) disable iff (rst)
        sym_we_o |-> ({1'b0, sym_addr_o} < SYM_LIM));

    // R6: column in range, entry advances only after the last column
    a_r6_col_range: assert property (@(posedge clk) disable iff (rst)
        pat_we_o |-> (pat_col_o <= COL_LAST));
    a_r6_entry_step: assert property (@(posedge clk) disable iff (rst)
        (pat_we_o && pat_col_o == COL_LAST) |-> (pat_ptr == pat_addr_o + 1'b1 && pat_col == '0));

    // R9: end of transfer always returns to command mode
    a_r9_end_to_cmd: assert property (@(posedge clk) disable iff (rst)
        xfer_end_i |=> (mode == M_CMD));

    // R11: reserved opcode leaves the decoder in command mode
    a_r11_reserved_idle: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && op == OP_NONE) |=> (mode == M_CMD));

endmodule

// File: rtl/vfd_ctrl_regs.sv
module vfd_ctrl_regs
    import vfd_cmd_pkg::*;
#(
    parameter int PORT_W = 4,
    parameter int DUTY_W = 3,
    parameter int DIGS_W = 4,
    parameter int ARG_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_sel_t          sel_i,
    input  logic [ARG_W-1:0]  arg_i,
    output logic [PORT_W-1:0] port_q,
    output logic [DUTY_W-1:0] duty_q,
    output logic [DIGS_W-1:0] digs_q,
    output logic [1:0]        lamp_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            port_q <= '0;
            duty_q <= '0;
            digs_q <= '0;
            lamp_q <= LAMP_RST;
        end else begin
            if (sel_i.port) port_q <= arg_i[PORT_W-1:0];
            if (sel_i.duty) duty_q <= arg_i[DUTY_W-1:0];
            if (sel_i.digs) digs_q <= arg_i[DIGS_W-1:0];
            if (sel_i.lamp) lamp_q <= arg_i[1:0];
        end
    end

    // R3: at most one register is selected by a command byte
    a_r3_single_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_i));

    // R8: reset values
    a_r8_reset_vals: assert property (@(posedge clk)
        rst |=> (port_q == '0 && duty_q == '0 && digs_q == '0 && lamp_q == LAMP_RST));

endmodule

// File: rtl/vfd_serial_cmd.sv
module vfd_serial_cmd
    import vfd_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CODE_AW     = 5,
    parameter int CODE_DEPTH  = 24,
    parameter int CODE_DW     = 8,
    parameter int PAT_AW      = 4,
    parameter int PAT_COLS    = 5,
    parameter int PAT_DW      = 7,
    parameter int SYM_AW      = 5,
    parameter int SYM_DEPTH   = 24,
    parameter int SYM_DW      = 4,
    parameter int PORT_W      = 4,
    parameter int DUTY_W      = 3,
    parameter int DIGS_W      = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ser_csn,
    input  logic                        ser_sck,
    input  logic                        ser_dat,
    output logic                        code_we,
    output logic [CODE_AW-1:0]          code_addr,
    output logic [CODE_DW-1:0]          code_wdata,
    output logic                        pat_we,
    output logic [PAT_AW-1:0]           pat_addr,
    output logic [$clog2(PAT_COLS)-1:0] pat_col,
    output logic [PAT_DW-1:0]           pat_wdata,
    output logic                        sym_we,
    output logic [SYM_AW-1:0]           sym_addr,
    output logic [SYM_DW-1:0]           sym_wdata,
    output logic [PORT_W-1:0]           port_q,
    output logic [DUTY_W-1:0]           duty_q,
    output logic [DIGS_W-1:0]           digits_q,
    output logic [1:0]                  lamp_q
);

    localparam int ARG_W = (PORT_W > DIGS_W) ? PORT_W : DIGS_W;

    logic              byte_vld;
    logic [BYTE_W-1:0] byte_val;
    logic              xfer_end;
    ctl_sel_t          ctl_sel;
    logic [ARG_W-1:0]  ctl_arg;

    vfd_ser_front #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_front (
        .clk        (clk),
        .rst        (rst),
        .csn_i      (ser_csn),
        .sck_i      (ser_sck),
        .dat_i      (ser_dat),
        .byte_vld_o (byte_vld),
        .byte_o     (byte_val),
        .xfer_end_o (xfer_end)
    );

    vfd_cmd_decode #(
        .CODE_AW    (CODE_AW),
        .CODE_DEPTH (CODE_DEPTH),
        .CODE_DW    (CODE_DW),
        .PAT_AW     (PAT_AW),
        .PAT_COLS   (PAT_COLS),
        .PAT_DW     (PAT_DW),
        .SYM_AW     (SYM_AW),
        .SYM_DEPTH  (SYM_DEPTH),
        .SYM_DW     (SYM_DW),
        .ARG_W      (ARG_W)
    ) u_decode (
        .clk         (clk),
        .rst         (rst),
        .byte_vld_i  (byte_vld),
        .byte_i      (byte_val),
        .xfer_end_i  (xfer_end),
        .code_we_o   (code_we),
        .code_addr_o (code_addr),
        .code_data_o (code_wdata),
        .pat_we_o    (pat_we),
        .pat_addr_o  (pat_addr),
        .pat_col_o   (pat_col),
        .pat_data_o  (pat_wdata),
        .sym_we_o    (sym_we),
        .sym_addr_o  (sym_addr),
        .sym_data_o  (sym_wdata),
        .ctl_sel_o   (ctl_sel),
        .ctl_arg_o   (ctl_arg)
    );

    vfd_ctrl_regs #(
        .PORT_W (PORT_W),
        .DUTY_W (DUTY_W),
        .DIGS_W (DIGS_W),
        .ARG_W  (ARG_W)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .sel_i  (ctl_sel),
        .arg_i  (ctl_arg),
        .port_q (port_q),
        .duty_q (duty_q),
        .digs_q (digits_q),
        .lamp_q (lamp_q)
    );

    // R3: registers move only in the cycle after a completed byte
    a_r3_regs_need_byte: assert property (@(posedge clk) disable iff (rst)
        (!$stable(port_q) || !$stable(duty_q) || !$stable(digits_q) || !$stable(lamp_q))
        |-> $past(byte_vld));

    // R2: memory strobes are mutually exclusive
    a_r2_one_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0({code_we, pat_we, sym_we}));

endmodule

// File: tb/vfd_serial_cmd_tb_top.sv
module vfd_serial_cmd_tb_top;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, ser_csn, ser_sck, ser_dat;
    logic       code_we;
    logic [4:0] code_addr;
    logic [7:0] code_wdata;
    logic       pat_we;
    logic [3:0] pat_addr;
    logic [2:0] pat_col;
    logic [6:0] pat_wdata;
    logic       sym_we;
    logic [4:0] sym_addr;
    logic [3:0] sym_wdata;
    logic [3:0] port_q;
    logic [2:0] duty_q;
    logic [3:0] digits_q;
    logic [1:0] lamp_q;

    vfd_serial_cmd dut_i (
        .clk(clk), .rst(rst), .ser_csn(ser_csn), .ser_sck(ser_sck), .ser_dat(ser_dat),
        .code_we(code_we), .code_addr(code_addr), .code_wdata(code_wdata),
        .pat_we(pat_we), .pat_addr(pat_addr), .pat_col(pat_col), .pat_wdata(pat_wdata),
        .sym_we(sym_we), .sym_addr(sym_addr), .sym_wdata(sym_wdata),
        .port_q(port_q), .duty_q(duty_q), .digits_q(digits_q), .lamp_q(lamp_q)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Write logs, filled away from the active edge
    logic [12:0] code_log [0:255];
    logic [13:0] pat_log  [0:255];
    logic [8:0]  sym_log  [0:255];
    int n_code = 0;
    int n_pat  = 0;
    int n_sym  = 0;

    always @(negedge clk) begin
        if (!rst && code_we && n_code < 256) begin
            code_log[n_code] = {code_addr, code_wdata};
            n_code++;
        end
        if (!rst && pat_we && n_pat < 256) begin
            pat_log[n_pat] = {pat_addr, pat_col, pat_wdata};
            n_pat++;
        end
        if (!rst && sym_we && n_sym < 256) begin
            sym_log[n_sym] = {sym_addr, sym_wdata};
            n_sym++;
        end
    end

    typedef struct packed {
        logic [7:0] cmd;
        logic [3:0] port;
        logic [2:0] duty;
        logic [3:0] digs;
        logic [1:0] lamp;
    } vec_t;

    // One-byte command transfers and the cumulative register state after each
    localparam vec_t VECS [0:7] = '{
        '{8'h8A, 4'hA, 3'd0, 4'h0, 2'b01},
        '{8'hA6, 4'hA, 3'd6, 4'h0, 2'b01},
        '{8'hCD, 4'hA, 3'd6, 4'hD, 2'b01},
        '{8'hE2, 4'hA, 3'd6, 4'hD, 2'b10},
        '{8'h1F, 4'hA, 3'd6, 4'hD, 2'b10},
        '{8'h9F, 4'hF, 3'd6, 4'hD, 2'b10},
        '{8'hBB, 4'hF, 3'd3, 4'hD, 2'b10},
        '{8'hE0, 4'hF, 3'd3, 4'hD, 2'b00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_fall();
        ser_csn = 1'b0;
        idle(4);
    endtask

    task automatic cs_rise();
        ser_csn = 1'b1;
        idle(12);
    endtask

    task automatic put_bit(input logic b);
        ser_dat = b;
        ser_sck = 1'b0;
        idle(4);
        ser_sck = 1'b1;
        idle(4);
    endtask

    task automatic put_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) put_bit(b[i]);
    endtask

    task automatic xfer1(input logic [7:0] b);
        cs_fall();
        put_byte(b);
        cs_rise();
    endtask

    function automatic logic [12:0] regs_now();
        return {port_q, duty_q, digits_q, lamp_q};
    endfunction

    initial begin : wdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int base;
        rst = 1'b1; ser_csn = 1'b1; ser_sck = 1'b1; ser_dat = 1'b0;
        idle(5);
        rst = 1'b0;
        idle(3);

        // R8: reset state
        chk("R8 regs", {19'd0, regs_now()}, {19'd0, 4'h0, 3'd0, 4'h0, 2'b01});
        chk("R8 strobes", {29'd0, code_we, pat_we, sym_we}, 32'd0);
        chk("R8 addrs", {19'd0, code_addr, pat_addr, sym_addr}, 32'd0);

        // R2 R3 R11: table of single-command transfers
        for (int v = 0; v < 8; v++) begin
            xfer1(VECS[v].cmd);
            chk($sformatf("R3/R11 vec%0d", v), {19'd0, regs_now()},
                {19'd0, VECS[v].port, VECS[v].duty, VECS[v].digs, VECS[v].lamp});
        end
        chk("R11 no writes", n_code + n_pat + n_sym, 0);

        // R1: shift clocks while select is high do nothing
        put_byte(8'h85);
        idle(12);
        chk("R1 csn high ignored", {28'd0, port_q}, 32'hF);

        // R3: control command keeps command mode, next byte is a command
        cs_fall();
        put_byte(8'h81);
        put_byte(8'hA2);
        cs_rise();
        chk("R3 back-to-back port", {28'd0, port_q}, 32'h1);
        chk("R3 back-to-back duty", {29'd0, duty_q}, 32'h2);

        // R4 R5: character-code writes across dummy slots and wrap
        base = n_code;
        cs_fall();
        put_byte(8'h36);
        for (int k = 0; k < 12; k++) put_byte(8'hC0 + 8'(k));
        cs_rise();
        chk("R5 code write count", n_code - base, 4);
        chk("R4 code w0", {19'd0, code_log[base]},   {19'd0, 5'd22, 8'hC0});
        chk("R4 code w1", {19'd0, code_log[base+1]}, {19'd0, 5'd23, 8'hC1});
        chk("R5 code wrap w2", {19'd0, code_log[base+2]}, {19'd0, 5'd0, 8'hCA});
        chk("R5 code wrap w3", {19'd0, code_log[base+3]}, {19'd0, 5'd1, 8'hCB});

        // R9: next transfer's first byte is a command
        base = n_code;
        xfer1(8'h8C);
        chk("R9 cmd after data mode", {28'd0, port_q}, 32'hC);
        chk("R9 no code write", n_code - base, 0);

        // R7 R5: symbol writes keep bits 3:0, skip dummies
        base = n_sym;
        cs_fall();
        put_byte(8'h77);
        put_byte(8'hF5);
        for (int k = 0; k < 8; k++) put_byte(8'h3A);
        put_byte(8'h9C);
        cs_rise();
        chk("R5 sym write count", n_sym - base, 2);
        chk("R7 sym w0", {23'd0, sym_log[base]},   {23'd0, 5'd23, 4'h5});
        chk("R7 sym wrap w1", {23'd0, sym_log[base+1]}, {23'd0, 5'd0, 4'hC});

        // R6: pattern columns, bit 7 ignored, entry wrap 15 -> 0
        base = n_pat;
        cs_fall();
        put_byte(8'h4F);
        for (int j = 0; j < 10; j++) put_byte(8'h80 | 8'(j * 9 + 3));
        cs_rise();
        chk("R6 pat write count", n_pat - base, 10);
        for (int j = 0; j < 10; j++) begin
            chk($sformatf("R6 pat w%0d", j), {18'd0, pat_log[base+j]},
                {18'd0, (j < 5) ? 4'hF : 4'h0, 3'(j % 5), 7'(j * 9 + 3)});
        end

        // R10: partial byte dropped in command phase
        cs_fall();
        for (int i = 0; i < 5; i++) put_bit(1'b1);
        cs_rise();
        xfer1(8'h83);
        chk("R10 partial cmd dropped", {28'd0, port_q}, 32'h3);

        // R10: partial byte dropped in data phase
        base = n_code;
        cs_fall();
        put_byte(8'h25);
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        cs_rise();
        chk("R10 partial data no write", n_code - base, 0);

        // R12: last data bit and select rise at the same instant
        base = n_code;
        cs_fall();
        put_byte(8'h21);
        for (int i = 0; i < 7; i++) put_bit(1'(8'h5A >> i));
        ser_dat = 1'b0;
        ser_sck = 1'b0;
        idle(4);
        ser_sck = 1'b1;
        ser_csn = 1'b1;
        idle(12);
        chk("R12 coincident byte written", n_code - base, 1);
        chk("R12 coincident data", {19'd0, code_log[base]}, {19'd0, 5'd1, 8'h5A});
        xfer1(8'h84);
        chk("R12 mode ended", {28'd0, port_q}, 32'h4);
        chk("R12 no extra write", n_code - base, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule